// File: doc/BRIEF.md
# Multiplexed Five-Digit Segment Display Refresher

This block turns two 8-bit binary values into five registered seven-segment digit patterns. The values are an operand and an accumulator. It has only one binary-to-decimal converter and one decimal-to-segment encoder. A free-running counter time-shares them across the five digit registers.

The low counter bits form a prescaler. The three bits above the prescaler name the current slot. In each slot the block picks a source value and a decimal digit of that value, encodes the digit, and writes the pattern into that slot's register. With the default prescaler width and a 50 MHz clock, every register is rewritten about 95 times a second.

The two leftmost digits show the operand. The three rightmost digits show the accumulator.

Top module: `disp_scan_top`

## Requirements
- R1: A synchronous active-high `rst` sets the refresh counter to zero and loads the blank pattern 7'h7F into all five digit outputs.
- R2: The refresh counter is PRESCALE_W+3 bits wide and advances by one every clock, wrapping to zero. Its top three bits are the slot number. Each slot therefore lasts 2^PRESCALE_W clocks, and one refresh frame is 8 slots.
- R3: Slot 0 writes the operand tens digit to `seg_op_tens_o`. Slot 1 writes the operand units digit to `seg_op_units_o`. Slots 2, 3 and 4 write the accumulator hundreds, tens and units digits to `seg_acc_hund_o`, `seg_acc_tens_o` and `seg_acc_units_o`. Slots 5, 6 and 7 write no output.
- R4: A digit register is written only on the clock edge that ends the second cycle of its own slot, that is when the prescaler field equals 1. The pattern written comes from the inputs present in that cycle. At every other edge the register holds its value.
- R5: The operand is shown as its decimal tens and units digits. Its hundreds digit is dropped, so 255 shows as 5 and 5.
- R6: The accumulator is shown as three decimal digits. Leading zeros are not suppressed, so 7 shows as 0, 0 and 7.
- R7: Segment outputs are active low, with bit 0 = segment a through bit 6 = segment g. The patterns for digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10 (hex).
- R8: Input changes that occur only outside the write cycle of a digit never reach that digit. This includes changes made and undone during slots 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| operand_i | input | 8 | Binary operand value |
| accum_i | input | 8 | Binary accumulator value |
| seg_op_tens_o | output | 7 | Operand tens digit pattern, active low |
| seg_op_units_o | output | 7 | Operand units digit pattern, active low |
| seg_acc_hund_o | output | 7 | Accumulator hundreds digit pattern, active low |
| seg_acc_tens_o | output | 7 | Accumulator tens digit pattern, active low |
| seg_acc_units_o | output | 7 | Accumulator units digit pattern, active low |

## Verification
A corrupted refresh counter or slot map shows up in two ways at the ports. A digit may change in the wrong slot, or it may take a value that belongs to a neighbouring digit or to the other source. Either is visible within one refresh frame of 8 slots. A fault in the converter or the encoder leaves a wrong pattern on a digit. That pattern appears on the write edge of its slot and stays until the next frame rewrites it. The bench therefore checks:
- the exact edge on which the first digits leave their blank state;
- input patterns that between them cover every decimal digit;
- input changes made outside the write cycles, which must leave every output unchanged.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
    localparam int SLOT_W     = 3;
    localparam int NUM_DIGITS = 5;
    localparam int SEG_W      = 7;
    localparam int BCD_DIGITS = 3;

    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t SEG_BLANK = 7'h7F;

    typedef enum logic [1:0] {
        DSEL_UNITS = 2'd0,
        DSEL_TENS  = 2'd1,
        DSEL_HUND  = 2'd2
    } dsel_e;
endpackage

// File: rtl/bin2bcd.sv
module bin2bcd #(
    parameter int BIN_W = 8,
    parameter int DIG_N = 3
) (
    input  logic [BIN_W-1:0]   bin_i,
    output logic [DIG_N*4-1:0] bcd_o
);
    localparam int SH_W = DIG_N * 4 + BIN_W;

    logic [SH_W-1:0] sh;

    // shift-and-add-3, fully unrolled
    always_comb begin
        sh = '0;
        sh[BIN_W-1:0] = bin_i;
        for (int b = 0; b < BIN_W; b++) begin
            for (int d = 0; d < DIG_N; d++) begin
                if (sh[BIN_W + 4*d +: 4] >= 4'd5) begin
                    sh[BIN_W + 4*d +: 4] = sh[BIN_W + 4*d +: 4] + 4'd3;
                end
            end
            sh = sh << 1;
        end
        bcd_o = sh[BIN_W +: DIG_N*4];
    end
endmodule

// File: rtl/seg7_encode.sv
module seg7_encode
    import disp_scan_pkg::*;
(
    input  logic [3:0] bcd_i,
    output seg_t       seg_o
);
    // active low, bit0 = a ... bit6 = g
    always_comb begin
        unique case (bcd_i)
            4'd0:    seg_o = 7'h40;
            4'd1:    seg_o = 7'h79;
            4'd2:    seg_o = 7'h24;
            4'd3:    seg_o = 7'h30;
            4'd4:    seg_o = 7'h19;
            4'd5:    seg_o = 7'h12;
            4'd6:    seg_o = 7'h02;
            4'd7:    seg_o = 7'h78;
            4'd8:    seg_o = 7'h00;
            4'd9:    seg_o = 7'h10;
            default: seg_o = SEG_BLANK;
        endcase
    end
endmodule

// File: rtl/slot_map.sv
module slot_map
    import disp_scan_pkg::*;
(
    input  logic [SLOT_W-1:0]     slot_i,
    output logic                  src_acc_o,
    output dsel_e                 dsel_o,
    output logic [NUM_DIGITS-1:0] we_mask_o
);
    always_comb begin
        src_acc_o = 1'b0;
        dsel_o    = DSEL_UNITS;
        we_mask_o = '0;
        unique case (slot_i)
            3'd0: begin src_acc_o = 1'b0; dsel_o = DSEL_TENS;  we_mask_o = 5'b00001; end
            3'd1: begin src_acc_o = 1'b0; dsel_o = DSEL_UNITS; we_mask_o = 5'b00010; end
            3'd2: begin src_acc_o = 1'b1; dsel_o = DSEL_HUND;  we_mask_o = 5'b00100; end
            3'd3: begin src_acc_o = 1'b1; dsel_o = DSEL_TENS;  we_mask_o = 5'b01000; end
            3'd4: begin src_acc_o = 1'b1; dsel_o = DSEL_UNITS; we_mask_o = 5'b10000; end
            default: begin src_acc_o = 1'b0; dsel_o = DSEL_UNITS; we_mask_o = '0; end
        endcase
    end
endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top
    import disp_scan_pkg::*;
#(
    parameter int PRESCALE_W = 16,
    parameter int VAL_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] operand_i,
    input  logic [VAL_W-1:0] accum_i,
    output logic [SEG_W-1:0] seg_op_tens_o,
    output logic [SEG_W-1:0] seg_op_units_o,
    output logic [SEG_W-1:0] seg_acc_hund_o,
    output logic [SEG_W-1:0] seg_acc_tens_o,
    output logic [SEG_W-1:0] seg_acc_units_o
);
    localparam int CNT_W = PRESCALE_W + SLOT_W;
    localparam int BCD_W = BCD_DIGITS * 4;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        seg_t [NUM_DIGITS-1:0]       dig;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0]         slot;
    logic [PRESCALE_W-1:0]     pre;
    logic                      strobe;
    logic                      src_acc;
    dsel_e                     dsel;
    logic [NUM_DIGITS-1:0]     we_mask;
    logic [NUM_DIGITS-1:0]     we_vec;
    logic [VAL_W-1:0]          src_val;
    logic [BCD_W-1:0]          bcd;
    logic [3:0]                nib;
    seg_t                      dec_seg;
    logic [NUM_DIGITS*SEG_W-1:0] dig_flat;

    assign slot   = st_q.cnt[CNT_W-1 -: SLOT_W];
    assign pre    = st_q.cnt[PRESCALE_W-1:0];
    assign strobe = (pre == PRESCALE_W'(1));

    slot_map u_map (
        .slot_i    (slot),
        .src_acc_o (src_acc),
        .dsel_o    (dsel),
        .we_mask_o (we_mask)
    );

    assign src_val = src_acc ? accum_i : operand_i;

    bin2bcd #(.BIN_W(VAL_W), .DIG_N(BCD_DIGITS)) u_bcd (
        .bin_i (src_val),
        .bcd_o (bcd)
    );

    always_comb begin
        unique case (dsel)
            DSEL_HUND: nib = bcd[11:8];
            DSEL_TENS: nib = bcd[7:4];
            default:   nib = bcd[3:0];
        endcase
    end

    seg7_encode u_seg (
        .bcd_i (nib),
        .seg_o (dec_seg)
    );

    assign we_vec = we_mask & {NUM_DIGITS{strobe}};

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (we_vec[i]) begin
                st_d.dig[i] = dec_seg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.dig <= {NUM_DIGITS{SEG_BLANK}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dig_flat        = st_q.dig;
    assign seg_op_tens_o   = st_q.dig[0];
    assign seg_op_units_o  = st_q.dig[1];
    assign seg_acc_hund_o  = st_q.dig[2];
    assign seg_acc_tens_o  = st_q.dig[3];
    assign seg_acc_units_o = st_q.dig[4];
endmodule

// File: rtl/disp_scan_checker.sv
module disp_scan_checker
    import disp_scan_pkg::*;
#(
    parameter int PRESCALE_W = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic [PRESCALE_W+SLOT_W-1:0]  cnt,
    input logic [NUM_DIGITS-1:0]         we_vec,
    input logic [SEG_W-1:0]              dec_seg,
    input logic [NUM_DIGITS*SEG_W-1:0]   dig_flat
);
    localparam int CNT_W = PRESCALE_W + SLOT_W;

    assert_reset_blank_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cnt == '0) && (dig_flat == {NUM_DIGITS{SEG_BLANK}}));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + CNT_W'(1));

    assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec));

    assert_idle_slots_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt[CNT_W-1 -: SLOT_W] >= SLOT_W'(5)) |-> (we_vec == '0));

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
            !$past(we_vec[i]) |-> $stable(dig_flat[i*SEG_W +: SEG_W]));

        assert_load_R4: assert property (@(posedge clk) disable iff (rst)
            $past(we_vec[i]) |-> dig_flat[i*SEG_W +: SEG_W] == $past(dec_seg));
    end
endmodule

bind disp_scan_top disp_scan_checker #(.PRESCALE_W(PRESCALE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt      (st_q.cnt),
    .we_vec   (we_vec),
    .dec_seg  (dec_seg),
    .dig_flat (dig_flat)
);

// File: tb/tb_disp_scan_top.sv
module tb_disp_scan_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW         = 2;
    localparam int SLOT_LEN   = 1 << PW;
    localparam int FRAME      = 8 * SLOT_LEN;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] operand = '0;
    logic [7:0] accum   = '0;
    logic [6:0] s_ot, s_ou, s_ah, s_at, s_au;

    int checks   = 0;
    int failures = 0;
    int edges    = 0;
    bit done     = 1'b0;

    disp_scan_top #(.PRESCALE_W(PW), .VAL_W(8)) dut (
        .clk             (clk),
        .rst             (rst),
        .operand_i       (operand),
        .accum_i         (accum),
        .seg_op_tens_o   (s_ot),
        .seg_op_units_o  (s_ou),
        .seg_acc_hund_o  (s_ah),
        .seg_acc_tens_o  (s_at),
        .seg_acc_units_o (s_au)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: pat = 7'h40; 1: pat = 7'h79; 2: pat = 7'h24; 3: pat = 7'h30;
            4: pat = 7'h19; 5: pat = 7'h12; 6: pat = 7'h02; 7: pat = 7'h78;
            8: pat = 7'h00; 9: pat = 7'h10; default: pat = 7'h7F;
        endcase
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // wait until the negedge at which counter value equals v
    task automatic wait_cnt(input int v);
        do @(negedge clk); while ((edges % FRAME) != v);
    endtask

    task automatic check_all(input string req, input int op, input int ac);
        chk({req, " op tens"},   s_ot, pat((op / 10) % 10));
        chk({req, " op units"},  s_ou, pat(op % 10));
        chk({req, " acc hund"},  s_ah, pat((ac / 100) % 10));
        chk({req, " acc tens"},  s_at, pat((ac / 10) % 10));
        chk({req, " acc units"}, s_au, pat(ac % 10));
    endtask

    task automatic t_reset();
        operand = 8'd42;
        accum   = 8'd137;
        do_reset();
        chk("R1 op tens",   s_ot, 7'h7F);
        chk("R1 op units",  s_ou, 7'h7F);
        chk("R1 acc hund",  s_ah, 7'h7F);
        chk("R1 acc tens",  s_at, 7'h7F);
        chk("R1 acc units", s_au, 7'h7F);
    endtask

    // counter 0 at release; slot s written on edge ending counter s*4+1
    task automatic t_first_writes();
        wait_cnt(1);
        chk("R4 slot0 not before write", s_ot, 7'h7F);
        wait_cnt(2);
        chk("R4 slot0 written", s_ot, pat(4));
        chk("R2 slot1 still blank", s_ou, 7'h7F);
        wait_cnt(SLOT_LEN + 1);
        chk("R2 slot1 not before write", s_ou, 7'h7F);
        wait_cnt(SLOT_LEN + 2);
        chk("R3 slot1 written", s_ou, pat(2));
        wait_cnt(2*SLOT_LEN + 1);
        chk("R2 slot2 not before write", s_ah, 7'h7F);
        wait_cnt(2*SLOT_LEN + 2);
        chk("R6 slot2 written", s_ah, pat(1));
        wait_cnt(4*SLOT_LEN + 2);
        check_all("R3 first frame", 42, 137);
    endtask

    task automatic t_values(input int op, input int ac, input string req);
        operand = op[7:0];
        accum   = ac[7:0];
        repeat (2*FRAME) @(negedge clk);
        check_all(req, op, ac);
    endtask

    task automatic t_ignore();
        operand = 8'd42;
        accum   = 8'd137;
        repeat (2*FRAME) @(negedge clk);
        wait_cnt(5*SLOT_LEN + 1);
        operand = 8'd96;
        accum   = 8'd88;
        wait_cnt(8*SLOT_LEN - 1);
        check_all("R8 idle slots", 42, 137);
        operand = 8'd42;
        accum   = 8'd137;
        wait_cnt(2);
        operand = 8'd73;
        wait_cnt(SLOT_LEN - 1);
        chk("R4 change after write", s_ot, pat(4));
        operand = 8'd42;
        wait_cnt(5*SLOT_LEN);
        check_all("R8 after frame", 42, 137);
    endtask

    initial begin
        t_reset();
        t_first_writes();
        t_values(0, 0, "R6 zeros");
        t_values(255, 255, "R5 max");
        t_values(9, 100, "R6 no blanking");
        t_values(199, 58, "R7 digits");
        t_values(86, 246, "R7 six");
        t_values(137, 7, "R5 hundreds dropped");
        t_ignore();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule